// File: doc/BRIEF.md
# Strobed-Enable Nonvolatile Memory Controller

This block connects a simple request/response port on the processor side to an external bytewide nonvolatile memory. That memory takes in the address on the falling edge of its chip enable. So the controller never leaves enable low between transfers. It runs each request as one enable pulse with four steps:

- drive the address with enable high;
- pull enable low and hold output-enable (read) or write-enable (write) for a fixed number of cycles;
- raise every strobe for a precharge interval;
- only then accept the next request.

Each phase length is a parameter counted in clock cycles. A supply-fault input holds off new transfers while the supply is out of tolerance. A transfer already in flight always runs to the end of its precharge, so the memory is never left with enable asserted.

Top module: `nvm_strobe_ctrl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` and `rsp_valid` are low, and `req_ready` is high when `supply_fault` is low.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. For the next `SETUP_CYC` cycles `mem_addr` carries the request address while `mem_ce_n` stays high. `mem_ce_n` then falls with `mem_addr` unchanged.
- R3: Every accepted request produces exactly one low pulse of `mem_ce_n`, lasting exactly `ACTIVE_CYC` cycles.
- R4: For a read (`req_write`=0), `mem_oe_n` is low and `mem_we_n` is high while `mem_ce_n` is low. `mem_dq_in` is sampled in the last low cycle. It is returned on `rsp_rdata` with `rsp_valid` high for exactly one cycle, the first cycle after `mem_ce_n` rises.
- R5: For a write (`req_write`=1), `mem_we_n` is low and `mem_oe_n` is high while `mem_ce_n` is low. `mem_dq_oe` is high only in those cycles, and `mem_dq_out` then carries the request data.
- R6: Between two consecutive low pulses, `mem_ce_n` stays high for at least `PRE_CYC + SETUP_CYC` cycles.
- R7: `req_ready` goes low from the acceptance edge until the `PRE_CYC` precharge cycles after the enable pulse have ended. It is high again in the following cycle.
- R8: While `supply_fault` is high, `req_ready` is low and no transfer starts, whatever `req_valid` does. A write offered during the fault leaves the memory unchanged.
- R9: If `supply_fault` rises during an enable pulse, the pulse still lasts `ACTIVE_CYC` cycles, precharge follows, and a read still delivers its response.
- R10: A write produces no `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DW | Read data |
| supply_fault | input | 1 | Supply out of tolerance; blocks new transfers |
| mem_addr | output | AW | Address to memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DW | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | DW | Data returned from memory |

## Verification
The hardest case to reach is a supply fault that rises while enable is already low. From the ports, that window is only `ACTIVE_CYC` cycles wide and opens a fixed number of cycles after acceptance. To hit it, the stimulus waits for the sampled falling edge of `mem_ce_n` and raises the fault on the very next sample. It then follows the pulse through precharge and holds the fault long enough to confirm that no second pulse appears. A write offered throughout a fault window is later read back, which shows at the ports that it never reached the memory.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

   typedef enum logic [1:0] {
      NVS_IDLE      = 2'd0,
      NVS_SETUP     = 2'd1,
      NVS_ACTIVE    = 2'd2,
      NVS_PRECHARGE = 2'd3
   } nvs_phase_e;

   function automatic int nvs_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/nvs_phase_seq.sv
module nvs_phase_seq
   import nvs_pkg::*;
#(
   parameter int SETUP_CYC  = 1,
   parameter int ACTIVE_CYC = 3,
   parameter int PRE_CYC    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   output nvs_phase_e phase,
   output logic       last_cyc
);

   localparam int MAXC = nvs_max3(SETUP_CYC, ACTIVE_CYC, PRE_CYC);
   localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

   generate
      if (SETUP_CYC < 1 || ACTIVE_CYC < 1 || PRE_CYC < 1) begin : g_bad_len
         $error("nvs_phase_seq: every phase needs at least one cycle");
      end
   endgenerate

   nvs_phase_e phase_q, phase_d;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         NVS_IDLE:      if (start)    phase_d = NVS_SETUP;
         NVS_SETUP:     if (last_cyc) phase_d = NVS_ACTIVE;
         NVS_ACTIVE:    if (last_cyc) phase_d = NVS_PRECHARGE;
         NVS_PRECHARGE: if (last_cyc) phase_d = NVS_IDLE;
         default:                     phase_d = NVS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= NVS_IDLE;
      else        phase_q <= phase_d;
   end

   // A ready-made variant for single-cycle phases: no counter at all.
   generate
      if (MAXC == 1) begin : g_no_count
         assign last_cyc = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q, load_val;
         logic          load;
         assign load = (phase_d != phase_q);
         always_comb begin
            unique case (phase_d)
               NVS_SETUP:     load_val = CW'(SETUP_CYC - 1);
               NVS_ACTIVE:    load_val = CW'(ACTIVE_CYC - 1);
               NVS_PRECHARGE: load_val = CW'(PRE_CYC - 1);
               default:       load_val = '0;
            endcase
         end
         always_ff @(posedge clk) begin
            if (!rst_n)              cnt_q <= '0;
            else if (load)           cnt_q <= load_val;
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end
         assign last_cyc = (cnt_q == '0);
      end
   endgenerate

   assign phase = phase_q;

endmodule

// File: rtl/nvs_strobe_dec.sv
module nvs_strobe_dec
   import nvs_pkg::*;
(
   input  nvs_phase_e phase,
   input  logic       wr,
   output logic       ce_n,
   output logic       oe_n,
   output logic       we_n,
   output logic       dq_oe
);

   logic live;

   assign live  = (phase == NVS_ACTIVE);
   assign ce_n  = ~live;
   assign oe_n  = ~(live & ~wr);
   assign we_n  = ~(live & wr);
   assign dq_oe = live & wr;

endmodule

// File: rtl/nvs_rd_capture.sv
module nvs_rd_capture #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_en,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] rdata,
   output logic          rvalid
);

   logic [DW-1:0] data_q;
   logic          valid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= cap_en;
         if (cap_en) data_q <= din;
      end
   end

   assign rdata  = data_q;
   assign rvalid = valid_q;

endmodule

// File: rtl/nvm_strobe_ctrl.sv
module nvm_strobe_ctrl
   import nvs_pkg::*;
#(
   parameter int AW         = 15,
   parameter int DW         = 8,
   parameter int SETUP_CYC  = 1,
   parameter int ACTIVE_CYC = 3,
   parameter int PRE_CYC    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   input  logic          supply_fault,
   output logic [AW-1:0] mem_addr,
   output logic          mem_ce_n,
   output logic          mem_oe_n,
   output logic          mem_we_n,
   output logic [DW-1:0] mem_dq_out,
   output logic          mem_dq_oe,
   input  logic [DW-1:0] mem_dq_in
);

   localparam int RUN_W = $clog2(SETUP_CYC + ACTIVE_CYC + PRE_CYC + 2) + 1;

   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("nvm_strobe_ctrl: AW and DW must be positive");
      end
   endgenerate

   nvs_phase_e    phase;
   logic          last_cyc, accept, cap_en;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic          wr_q;

   // New work only from idle and only with a healthy supply.
   assign req_ready = (phase == NVS_IDLE) && !supply_fault;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         wr_q    <= 1'b0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         wr_q    <= req_write;
      end
   end

   nvs_phase_seq #(
      .SETUP_CYC (SETUP_CYC),
      .ACTIVE_CYC(ACTIVE_CYC),
      .PRE_CYC   (PRE_CYC)
   ) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .phase   (phase),
      .last_cyc(last_cyc)
   );

   nvs_strobe_dec i_dec (
      .phase(phase),
      .wr   (wr_q),
      .ce_n (mem_ce_n),
      .oe_n (mem_oe_n),
      .we_n (mem_we_n),
      .dq_oe(mem_dq_oe)
   );

   assign cap_en = (phase == NVS_ACTIVE) && last_cyc && !wr_q;

   nvs_rd_capture #(.DW(DW)) i_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .cap_en(cap_en),
      .din   (mem_dq_in),
      .rdata (rsp_rdata),
      .rvalid(rsp_valid)
   );

   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;

   // Run-length trackers of the enable level, used by the checks below.
   logic [RUN_W-1:0] low_run, high_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_run  <= '0;
         high_run <= '1;
      end else if (mem_ce_n) begin
         low_run <= '0;
         if (high_run != '1) high_run <= high_run + 1'b1;
      end else begin
         high_run <= '0;
         if (low_run != '1) low_run <= low_run + 1'b1;
      end
   end

   assert_addr_stable_at_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ce_n) |-> $stable(mem_addr));

   assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_ce_n) |-> (low_run == RUN_W'(ACTIVE_CYC)));

   assert_rsp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_precharge_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ce_n) |-> (high_run >= RUN_W'(SETUP_CYC + PRE_CYC)));

   assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   assert_fault_holds_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_fault && phase == NVS_IDLE) |=> (phase == NVS_IDLE));

   assert_pulse_ends_in_precharge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |=> (!mem_ce_n || phase == NVS_PRECHARGE));

   assert_write_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |=> !rsp_valid);

endmodule

// File: tb/test_nvm_strobe_ctrl.sv
module test_nvm_strobe_ctrl;

   localparam int AW = 15;
   localparam int DW = 8;
   localparam int SETUP_CYC  = 1;
   localparam int ACTIVE_CYC = 3;
   localparam int PRE_CYC    = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0, supply_fault = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_out, mem_dq_in;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   nvm_strobe_ctrl #(
      .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .ACTIVE_CYC(ACTIVE_CYC), .PRE_CYC(PRE_CYC)
   ) i_nvm_strobe_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .supply_fault(supply_fault),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // Behavioural memory: address taken on the falling edge of enable.
   logic [7:0] mem_arr [256];
   logic [7:0] shadow  [256];
   logic [7:0] lat_addr = 8'h00;

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem_arr[i] = 8'(i * 7 + 3);
         shadow[i]  = 8'(i * 7 + 3);
      end
   end

   always @(negedge mem_ce_n) lat_addr = mem_addr[7:0];
   assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? mem_arr[lat_addr] : 8'h00;
   always @(negedge clk) if (!mem_ce_n && !mem_we_n) mem_arr[lat_addr] = mem_dq_out;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Scoreboard of expected read data.
   logic [7:0] exp_q [$];

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R10", "response with nothing outstanding", rsp_rdata, 0);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(rsp_rdata == e, "R4", "read data", rsp_rdata, e);
         end
      end
   end

   // Enable gap monitor.
   int  hi_run = 1000;
   logic prev_ce = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_ce && !mem_ce_n)
            check(hi_run >= SETUP_CYC + PRE_CYC, "R6", "enable-high gap", hi_run, SETUP_CYC + PRE_CYC);
         hi_run  = mem_ce_n ? hi_run + 1 : 0;
         prev_ce = mem_ce_n;
      end
   end

   task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      if (wr) shadow[a[7:0]] = d;
      else    exp_q.push_back(shadow[a[7:0]]);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic run_access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
      int n;
      issue(wr, a, d);
      n = 1;
      while (mem_ce_n && n < 50) begin
         check(mem_addr == a, "R2", "setup address", mem_addr, a);
         check(!req_ready, "R7", "ready during setup", req_ready, 0);
         @(negedge clk); n++;
      end
      check(n == SETUP_CYC + 1, "R2", "cycles to enable fall", n, SETUP_CYC + 1);
      check(mem_addr == a, "R2", "address at fall", mem_addr, a);
      n = 0;
      while (!mem_ce_n && n < 50) begin
         if (wr) begin
            check(!mem_we_n && mem_oe_n && mem_dq_oe, "R5", "write strobes",
                  {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b011);
            check(mem_dq_out == d, "R5", "write data", mem_dq_out, d);
         end else begin
            check(mem_we_n && !mem_oe_n && !mem_dq_oe, "R4", "read strobes",
                  {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b100);
         end
         n++; @(negedge clk);
      end
      check(n == ACTIVE_CYC, "R3", "enable low length", n, ACTIVE_CYC);
      if (wr) check(!rsp_valid, "R10", "no response for write", rsp_valid, 0);
      n = 0;
      while (!req_ready && n < 50) begin
         check(mem_ce_n && !mem_dq_oe, "R7", "strobes idle in precharge", mem_ce_n, 1);
         n++; @(negedge clk);
      end
      check(n == PRE_CYC, "R7", "precharge length before ready", n, PRE_CYC);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes after reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
      check(!mem_dq_oe && !rsp_valid, "R1", "bus and response after reset",
            {mem_dq_oe, rsp_valid}, 0);
      check(req_ready, "R1", "ready after reset", req_ready, 1);

      run_access(1'b1, 15'h0010, 8'hA5);
      run_access(1'b1, 15'h7FFF, 8'h3C);
      run_access(1'b0, 15'h0010, 8'h00);
      run_access(1'b0, 15'h7FFF, 8'h00);
      run_access(1'b0, 15'h0042, 8'h00);
      for (int i = 0; i < 8; i++)
         run_access((i % 3) == 0, 15'(i * 37 + 5), 8'(i * 29 + 1));

      // R8: a write offered during a fault must not start.
      @(negedge clk);
      supply_fault = 1'b1;
      req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0055; req_wdata = 8'hEE;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         check(!req_ready && mem_ce_n, "R8", "blocked while fault",
               {req_ready, mem_ce_n}, 2'b01);
      end
      req_valid = 1'b0;
      @(negedge clk);
      supply_fault = 1'b0;
      run_access(1'b0, 15'h0055, 8'h00);

      // R9: fault rising inside an enable pulse.
      issue(1'b0, 15'h0020, 8'h00);
      while (mem_ce_n) @(negedge clk);
      supply_fault = 1'b1;
      begin
         int n;
         n = 1;
         @(negedge clk);
         while (!mem_ce_n && n < 50) begin n++; @(negedge clk); end
         check(n == ACTIVE_CYC, "R9", "pulse length under fault", n, ACTIVE_CYC);
         check(rsp_valid, "R9", "read response under fault", rsp_valid, 1);
      end
      for (int i = 0; i < PRE_CYC + 6; i++) begin
         check(mem_ce_n && !req_ready, "R9", "idle and blocked after pulse",
               {mem_ce_n, req_ready}, 2'b10);
         @(negedge clk);
      end
      supply_fault = 1'b0;
      @(negedge clk);
      check(req_ready, "R8", "ready after fault clears", req_ready, 1);

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R4", "responses outstanding", exp_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule